// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable model of a synchronous static memory built for burst cache-line traffic. Address, write data, byte-lane controls and both burst-start strobes are captured on the rising clock edge. Read data is not registered on the way out. The word addressed by the captured state is presented combinationally in the cycle after the edge that captured the request. This is the flow-through style.

A burst opens when either of two start strobes is seen while the chip select is high. One strobe is the processor-side strobe and the other is the controller-side strobe. A burst loads the full external address. Further beats reuse the captured upper address bits. The two low bits are generated from a 2-bit beat counter, which steps only when the advance input is high. A static order pin chooses between linear stepping and interleaved stepping.

Writes are merged from three controls into a per-lane mask: a global write, a write enable, and one select per byte lane. The array commits a write on the clock edge that follows the capture. The output bus is replaced by a data word plus a valid flag.

Top module: `fts_burst_sram`

## Requirements
- R1: After reset and before any burst starts, `rvalid` is 0 and `rdata` is all zeros.
- R2: A start strobe (`strb_cpu` or `strb_ctl`) seen on a rising edge with `chip_sel` high loads `addr` and resets the beat count. If that cycle is a read and `out_en` is high, the word at `addr` appears on `rdata` with `rvalid` high in the cycle following that edge, with no extra register stage.
- R3: With `order_il` low, the beat address low bits equal (start low bits + beat count) modulo 4. For example, a start offset of 1 yields 1,2,3,0.
- R4: With `order_il` high, the beat address low bits equal start low bits XOR beat count. For example, a start offset of 2 yields 2,3,0,1.
- R5: Outside a start cycle, the beat count steps by one only on edges where `adv` is high. Otherwise the same location is accessed again.
- R6: After four advances the beat address returns to the start offset. Address bits above bit 1 never change during a burst.
- R7: With `glob_wr` low, byte lane k is written when `wr_en` and `lane_wr[k]` are both high. Lane 0 is `rdata`/`wdata` bits 8:0 and lane 1 is bits 17:9. A lane that is not selected keeps its old contents. The new data is readable in the very next cycle.
- R8: With `glob_wr` high, every lane is written, whatever the values of `wr_en` and `lane_wr`.
- R9: When both strobes are high on the same edge, the processor-side strobe wins. The cycle is a read and writes nothing, even if the write controls are active.
- R10: A start strobe seen with `chip_sel` low deselects the device. `rvalid` is low from the next cycle on. Continue cycles then neither read nor write until a new selected start.
- R11: `out_en` acts without a clock. Whenever it is low, `rvalid` is 0 and `rdata` is all zeros.
- R12: During a write cycle, `rvalid` stays low and `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | External word address for a burst start |
| strb_cpu | input | 1 | Processor-side burst start strobe (read start, has priority) |
| strb_ctl | input | 1 | Controller-side burst start strobe |
| adv | input | 1 | Step the beat counter in a continue cycle |
| chip_sel | input | 1 | Chip select, sampled only with a start strobe |
| wr_en | input | 1 | Write enable qualifying the lane selects |
| lane_wr | input | LANES | Per-lane write select, bit 0 = low lane |
| glob_wr | input | 1 | Write all lanes |
| out_en | input | 1 | Asynchronous output enable |
| order_il | input | 1 | Static beat order: 0 linear, 1 interleaved |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Flow-through read data, zero when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
The hardest state to reach is a burst that has gone all the way around its four-beat window. The bench reaches it by opening a read at an address whose low bits are 3 and upper bits are non-zero, then advancing five times in a row. This shows both the return to the start offset and the absence of carry into the upper bits. A second hard case is a write attempted after a deselect. To reach it, the bench issues a deselecting start while the global write is held high, keeps that write request up through the following continue cycles, and then reopens a burst to read the targeted words back. Lane masking is exposed the same way: the bench writes one lane with data that differs from the stored word, then reads the word back in the following cycle.

// File: rtl/fts_pkg.sv
package fts_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_t;

    // Low two bits of a beat address from the start offset and beat count.
    function automatic logic [1:0] beat_offset(
        input logic [1:0] start,
        input logic [1:0] step,
        input logic       il
    );
        logic [1:0] r;
        if (il) r = start ^ step;
        else    r = start + step;
        return r;
    endfunction

endpackage

// File: rtl/fts_wmask_dec.sv
module fts_wmask_dec #(
    parameter int LANES = 2
) (
    input  logic             glob_wr,
    input  logic             wr_en,
    input  logic [LANES-1:0] lane_wr,
    output logic [LANES-1:0] mask
);

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign mask[g] = glob_wr | (wr_en & lane_wr[g]);
        end
    endgenerate

endmodule

// File: rtl/fts_burst_addr.sv
module fts_burst_addr #(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        cnt,
    input  logic              order_il,
    output logic [ADDR_W-1:0] eff
);
    import fts_pkg::*;

    assign eff = {base[ADDR_W-1:2], beat_offset(base[1:0], cnt, order_il)};

endmodule

// File: rtl/fts_array.sv
module fts_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 18,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  we,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] rd
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int LW    = DATA_W / LANES;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] merged;

    assign rd = mem[addr];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_merge
            assign merged[g*LW +: LW] = we[g] ? wd[g*LW +: LW] : rd[g*LW +: LW];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (|we) mem[addr] <= merged;
    end

endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 18,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strb_cpu,
    input  logic              strb_ctl,
    input  logic              adv,
    input  logic              chip_sel,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_wr,
    input  logic              glob_wr,
    input  logic              out_en,
    input  logic              order_il,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    import fts_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        acc_t              acc;
        logic [LANES-1:0]  mask;
        logic [DATA_W-1:0] wdata;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0]  mask_in;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] arr_rd;
    logic [LANES-1:0]  arr_we;

    fts_wmask_dec #(.LANES(LANES)) u_mask (
        .glob_wr (glob_wr),
        .wr_en   (wr_en),
        .lane_wr (lane_wr),
        .mask    (mask_in)
    );

    fts_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .base     (st_q.base),
        .cnt      (st_q.cnt),
        .order_il (order_il),
        .eff      (eff_addr)
    );

    fts_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_array (
        .clk  (clk),
        .addr (eff_addr),
        .we   (arr_we),
        .wd   (st_q.wdata),
        .rd   (arr_rd)
    );

    always_comb begin
        st_d = st_q;
        if (strb_cpu || strb_ctl) begin
            if (!chip_sel) begin
                st_d.acc  = ACC_IDLE;
                st_d.mask = '0;
            end else begin
                st_d.base  = addr;
                st_d.cnt   = 2'd0;
                st_d.wdata = wdata;
                if (strb_cpu) begin
                    st_d.acc  = ACC_READ;
                    st_d.mask = '0;
                end else begin
                    st_d.mask = mask_in;
                    st_d.acc  = (|mask_in) ? ACC_WRITE : ACC_READ;
                end
            end
        end else if (st_q.acc != ACC_IDLE) begin
            if (adv) st_d.cnt = st_q.cnt + 2'd1;
            st_d.wdata = wdata;
            st_d.mask  = mask_in;
            st_d.acc   = (|mask_in) ? ACC_WRITE : ACC_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.base  <= '0;
            st_q.cnt   <= 2'd0;
            st_q.acc   <= ACC_IDLE;
            st_q.mask  <= '0;
            st_q.wdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign arr_we = (st_q.acc == ACC_WRITE) ? st_q.mask : '0;
    assign rvalid = (st_q.acc == ACC_READ) && out_en;
    assign rdata  = rvalid ? arr_rd : '0;

    AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_cpu && !strb_ctl) |=> $stable(st_q.base)); // R6

    AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_cpu && !strb_ctl && !adv) |=> $stable(st_q.cnt)); // R5

    AST_CPU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_cpu && chip_sel) |=> (arr_we == '0)); // R9

    AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ((strb_cpu || strb_ctl) && !chip_sel) |=> (!rvalid && arr_we == '0)); // R10

    AST_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (|arr_we) |-> !rvalid); // R12

endmodule

// File: tb/fts_burst_sram_bench.sv
module fts_burst_sram_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  b_addr = '0;
    logic        b_cpu = 1'b0, b_ctl = 1'b0, b_adv = 1'b0, b_sel = 1'b0;
    logic        b_we = 1'b0, b_glob = 1'b0, b_oe = 1'b1, b_il = 1'b0;
    logic [1:0]  b_lane = 2'b00;
    logic [17:0] b_wdata = '0;
    logic [17:0] rdata;
    logic        rvalid;

    int n_tests = 0;
    int n_fail  = 0;
    string cur  = "R1";

    // reference model state
    bit          m_act = 0, m_wr = 0;
    int          m_base = 0, m_cnt = 0;
    logic [1:0]  m_mask = '0;
    logic [17:0] m_wdata = '0;
    logic [17:0] mdat [64];
    bit          known [64];

    always #4 clk = ~clk;

    fts_burst_sram u_fts_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(b_addr), .strb_cpu(b_cpu), .strb_ctl(b_ctl),
        .adv(b_adv), .chip_sel(b_sel), .wr_en(b_we), .lane_wr(b_lane), .glob_wr(b_glob),
        .out_en(b_oe), .order_il(b_il), .wdata(b_wdata), .rdata(rdata), .rvalid(rvalid)
    );

    function automatic int m_eff();
        int lo;
        int st = m_base % 4;
        if (b_il) lo = st ^ m_cnt;
        else      lo = (st + m_cnt) % 4;
        return (m_base / 4) * 4 + lo;
    endfunction

    function automatic logic [1:0] calc_mask();
        logic [1:0] m;
        m[0] = b_glob || (b_we && b_lane[0]);
        m[1] = b_glob || (b_we && b_lane[1]);
        return m;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0;
            m_wr  = 0;
        end else begin
            if (m_act && m_wr) begin
                int e = m_eff();
                if (m_mask[0]) mdat[e][8:0]  = m_wdata[8:0];
                if (m_mask[1]) mdat[e][17:9] = m_wdata[17:9];
                if (m_mask == 2'b11) known[e] = 1;
            end
            if (b_cpu || b_ctl) begin
                if (!b_sel) begin
                    m_act = 0;
                    m_wr  = 0;
                end else begin
                    m_act   = 1;
                    m_base  = int'(b_addr);
                    m_cnt   = 0;
                    m_wdata = b_wdata;
                    if (b_cpu) begin
                        m_mask = 2'b00;
                        m_wr   = 0;
                    end else begin
                        m_mask = calc_mask();
                        m_wr   = (m_mask != 2'b00);
                    end
                end
            end else if (m_act) begin
                if (b_adv) m_cnt = (m_cnt + 1) % 4;
                m_wdata = b_wdata;
                m_mask  = calc_mask();
                m_wr    = (m_mask != 2'b00);
            end
        end
    end

    task automatic check();
        bit          ev;
        logic [17:0] ed;
        int          e;
        bit          bad;
        e  = m_eff();
        ev = m_act && !m_wr && b_oe;
        ed = ev ? mdat[e] : 18'd0;
        bad = (rvalid !== ev);
        if (!ev && rdata !== 18'd0) bad = 1;
        if (ev && known[e] && rdata !== ed) bad = 1;
        n_tests++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h (addr %0d)",
                     cur, rvalid, rdata, ev, ed, e);
        end
    endtask

    task automatic go(bit cpu, bit ctl, bit adv, bit sel, bit we, logic [1:0] lane,
                      bit glob, int a, logic [17:0] d);
        b_cpu = cpu; b_ctl = ctl; b_adv = adv; b_sel = sel; b_we = we;
        b_lane = lane; b_glob = glob; b_addr = 6'(a); b_wdata = d;
        @(posedge clk);
        @(negedge clk);
        check();
    endtask

    task automatic idle_cyc();
        go(0, 0, 0, 0, 0, 2'b00, 0, 0, 18'd0);
    endtask

    function automatic logic [17:0] pat(int a);
        return 18'(a * 4099 + 17);
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) begin
            mdat[i]  = '0;
            known[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur = "R1";
        check();
        idle_cyc();

        // fill with global write bursts; output quiet in write cycles
        cur = "R8";
        for (int g = 0; g < 16; g++) begin
            go(0, 1, 0, 1, 0, 2'b00, 1, g * 4, pat(g * 4));
            cur = "R12";
            for (int b = 1; b < 4; b++) go(0, 0, 1, 0, 0, 2'b00, 1, 0, pat(g * 4 + b));
            cur = "R8";
        end

        // starts with both strobes, read without output register
        cur = "R2";
        go(1, 0, 0, 1, 0, 2'b00, 0, 37, 18'd0);
        go(0, 1, 0, 1, 0, 2'b00, 0, 42, 18'd0);
        go(0, 1, 0, 1, 1, 2'b00, 0, 9, 18'd0);

        // linear order from offset 1
        cur = "R3";
        go(1, 0, 0, 1, 0, 2'b00, 0, 5, 18'd0);
        for (int b = 0; b < 3; b++) go(0, 0, 1, 0, 0, 2'b00, 0, 0, 18'd0);

        // interleaved order from offset 2 and 1
        cur = "R4";
        b_il = 1'b1;
        go(1, 0, 0, 1, 0, 2'b00, 0, 22, 18'd0);
        for (int b = 0; b < 3; b++) go(0, 0, 1, 0, 0, 2'b00, 0, 0, 18'd0);
        go(0, 1, 0, 1, 0, 2'b00, 0, 49, 18'd0);
        for (int b = 0; b < 3; b++) go(0, 0, 1, 0, 0, 2'b00, 0, 0, 18'd0);
        b_il = 1'b0;
        idle_cyc();

        // wrap from offset 3 with non-zero upper bits
        cur = "R6";
        go(1, 0, 0, 1, 0, 2'b00, 0, 27, 18'd0);
        for (int b = 0; b < 5; b++) go(0, 0, 1, 0, 0, 2'b00, 0, 0, 18'd0);
        b_il = 1'b1;
        go(1, 0, 0, 1, 0, 2'b00, 0, 63, 18'd0);
        for (int b = 0; b < 5; b++) go(0, 0, 1, 0, 0, 2'b00, 0, 0, 18'd0);
        b_il = 1'b0;

        // advance held low repeats location
        cur = "R5";
        go(1, 0, 0, 1, 0, 2'b00, 0, 12, 18'd0);
        go(0, 0, 0, 0, 0, 2'b00, 0, 0, 18'd0);
        go(0, 0, 0, 0, 0, 2'b00, 0, 0, 18'd0);
        go(0, 0, 1, 0, 0, 2'b00, 0, 0, 18'd0);
        go(0, 0, 0, 0, 0, 2'b00, 0, 0, 18'd0);
        go(0, 0, 1, 0, 0, 2'b00, 0, 0, 18'd0);

        // per-lane writes with readback next cycle
        cur = "R7";
        go(0, 1, 0, 1, 1, 2'b01, 0, 17, 18'h3ABCD);
        go(0, 0, 0, 0, 0, 2'b00, 0, 0, 18'd0);
        go(0, 0, 0, 0, 1, 2'b10, 0, 0, 18'h15555);
        go(0, 0, 0, 0, 0, 2'b00, 0, 0, 18'd0);
        go(0, 0, 1, 0, 1, 2'b11, 0, 0, 18'h2F0F0);
        go(0, 0, 0, 0, 0, 2'b00, 0, 0, 18'd0);
        go(0, 0, 1, 0, 0, 2'b11, 0, 0, 18'h01234);
        go(0, 0, 0, 0, 1, 2'b00, 0, 0, 18'h01234);
        cur = "R8";
        go(0, 1, 0, 1, 0, 2'b00, 1, 33, 18'h0BEEF);
        go(0, 0, 0, 0, 0, 2'b00, 0, 0, 18'd0);

        // both strobes: processor side wins, read only
        cur = "R9";
        go(1, 1, 0, 1, 1, 2'b11, 1, 10, 18'h3FFFF);
        go(0, 0, 0, 0, 0, 2'b00, 0, 0, 18'd0);
        go(0, 0, 1, 0, 0, 2'b00, 0, 0, 18'd0);

        // deselect blocks reads and writes
        cur = "R10";
        go(1, 0, 0, 1, 0, 2'b00, 0, 44, 18'd0);
        go(0, 1, 0, 0, 0, 2'b00, 1, 44, 18'h11111);
        go(0, 0, 1, 0, 0, 2'b00, 1, 0, 18'h22222);
        go(0, 0, 1, 0, 1, 2'b11, 0, 0, 18'h33333);
        go(1, 0, 0, 0, 0, 2'b00, 0, 44, 18'd0);
        go(1, 0, 0, 1, 0, 2'b00, 0, 44, 18'd0);
        for (int b = 0; b < 3; b++) go(0, 0, 1, 0, 0, 2'b00, 0, 0, 18'd0);

        // asynchronous output enable
        cur = "R11";
        go(1, 0, 0, 1, 0, 2'b00, 0, 50, 18'd0);
        b_oe = 1'b0;
        #1 check();
        go(0, 0, 1, 0, 0, 2'b00, 0, 0, 18'd0);
        b_oe = 1'b1;
        #1 check();
        go(0, 0, 1, 0, 0, 2'b00, 0, 0, 18'd0);

        // reset returns to idle
        cur = "R1";
        rst_n = 1'b0;
        go(0, 0, 0, 0, 0, 2'b00, 0, 0, 18'd0);
        rst_n = 1'b1;
        go(0, 0, 0, 0, 0, 2'b00, 1, 0, 18'h3FFFF);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule